// File: doc/BRIEF.md
# Banked ROM Slot Decoder

This block decodes one cartridge slot on an 8-bit CPU bus with 16-bit addresses and 8-bit data. It serves three address regions: an 8 kB ROM window at 0x4000–0x5FFF, an 8 kB battery-backed SRAM window at 0x6000–0x7FFF, and a 16-byte I/O area at 0x7FC0–0x7FCF that sits inside the SRAM window and takes priority over it. The ROM window reaches sixteen 8 kB ROM pages. The page number has no flip-flop of its own. It is the low nibble of the SRAM byte at SRAM offset 0x1FC4, so any write to that byte remaps the ROM window.

The block has one external SRAM port with zero-wait asynchronous reads. During a ROM-window read, the block points that port at the selector byte and forms the ROM address from the nibble that comes back, all in the same cycle. Read data is combinational from the bus address and the read strobe. Reads with nothing behind them return the open-bus value 0xFF. The two UART registers in the I/O area are only decoded into a chip-select for an external UART. The firmware switch status input is asynchronous, so it passes through a reset synchronizer before it can be read.

Top module: `banked_rom_slot`

## Requirements
- R1: A read in 0x4000–0x5FFF asserts `rom_cs`. It drives `rom_addr` = {low 4 bits of the SRAM byte at offset 0x1FC4, `bus_addr[12:0]`} (selector nibble in bits 16:13) and returns `rom_rdata`. The selector's upper 4 bits have no effect on the page.
- R2: A read in 0x6000–0x7FFF outside 0x7FC0–0x7FCF returns the SRAM byte at `bus_addr[12:0]`. This includes the addresses 0x7FBF and 0x7FD0 on either side of the I/O area.
- R3: A write in 0x6000–0x7FFF outside the I/O area, or at 0x7FC4, asserts `sram_cs` and `sram_we` with `sram_addr` = `bus_addr[12:0]` and `sram_wdata` = `bus_wdata`. A write to 0x7FC4 changes the ROM page used by the next ROM-window read.
- R4: A read at 0x7FC4 returns the whole selector byte, upper nibble included, exactly as it was last written.
- R5: A read at 0x7FC6 returns 0xFB when the synchronized `fw_switch` is high and 0xFF when it is low. A change on `fw_switch` becomes visible after SYNC_STAGES rising clock edges. From reset the synchronized value is low.
- R6: An access at 0x7FC0 or 0x7FC1 asserts `uart_cs`, with `uart_reg` equal to `bus_addr[0]` (0 = data, 1 = command/status). The read returns 0xFF and the SRAM is not selected.
- R7: Every other I/O offset (2, 3, 5, 7–15) reads 0xFF. A write there does not assert `sram_cs`, `sram_we` or `uart_cs`.
- R8: Any address below 0x4000 or at 0x8000 and above reads 0xFF. An access there asserts none of `rom_cs`, `sram_cs` or `uart_cs`, and a write there leaves SRAM contents unchanged.
- R9: A write in 0x4000–0x5FFF asserts neither `rom_cs` nor `sram_we` and changes no SRAM byte.
- R10: While `bus_rd` is low, `bus_rdata` is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; the SRAM write and the switch synchronizer act on its rising edge |
| rst_n | input | 1 | Active-low reset of the switch synchronizer |
| bus_addr | input | 16 | CPU address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | CPU write data |
| bus_rdata | output | 8 | Read data, combinational |
| rom_addr | output | 17 | ROM byte address: page nibble over 13-bit window offset |
| rom_cs | output | 1 | ROM chip select |
| rom_rdata | input | 8 | ROM data |
| sram_addr | output | 13 | SRAM byte address |
| sram_cs | output | 1 | SRAM chip select |
| sram_we | output | 1 | SRAM write enable |
| sram_wdata | output | 8 | SRAM write data |
| sram_rdata | input | 8 | SRAM asynchronous read data |
| uart_cs | output | 1 | UART chip select |
| uart_reg | output | 1 | UART register pick: 0 data, 1 command/status |
| fw_switch | input | 1 | Raw firmware switch status, asynchronous |

## Verification
The bench builds the block with SYNC_STAGES set to 3 instead of the default 2. With that setting, a mutant that drops or adds a synchronizer stage makes the switch status read flip on the wrong edge, and the bench detects it. All other parameters stay at their defaults, so the real address map is checked, including the I/O-area edges at 0x7FBF and 0x7FD0 and the ROM pages that sit under a selector byte with a non-zero upper nibble.

// File: rtl/brs_pkg.sv
package brs_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int WIN_W  = 13;
  localparam int PAGE_W = 4;
  localparam int IO_W   = 4;

  localparam logic [ADDR_W-1:0] ROM_BASE  = 16'h4000;
  localparam logic [ADDR_W-1:0] SRAM_BASE = 16'h6000;
  localparam logic [ADDR_W-1:0] IO_BASE   = 16'h7FC0;
  localparam logic [WIN_W-1:0]  SEL_LOC   = 13'h1FC4;

  localparam logic [IO_W-1:0] OFF_UDATA = 4'd0;
  localparam logic [IO_W-1:0] OFF_UCMD  = 4'd1;
  localparam logic [IO_W-1:0] OFF_SEL   = 4'd4;
  localparam logic [IO_W-1:0] OFF_SW    = 4'd6;

  localparam logic [DATA_W-1:0] OPEN_BUS  = 8'hFF;
  localparam logic [DATA_W-1:0] SW_ACTIVE = 8'hFB;

  typedef enum logic [1:0] {RG_NONE, RG_ROM, RG_SRAM, RG_IO} region_e;
endpackage

// File: rtl/brs_decode.sv
module brs_decode
  import brs_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [IO_W-1:0]   io_off
);
  // The I/O area lies inside the SRAM window and is tested first.
  always_comb begin
    io_off = addr[IO_W-1:0];
    if (addr[ADDR_W-1:IO_W] == IO_BASE[ADDR_W-1:IO_W])
      region = RG_IO;
    else if (addr[ADDR_W-1:WIN_W] == ROM_BASE[ADDR_W-1:WIN_W])
      region = RG_ROM;
    else if (addr[ADDR_W-1:WIN_W] == SRAM_BASE[ADDR_W-1:WIN_W])
      region = RG_SRAM;
    else
      region = RG_NONE;
  end
endmodule

// File: rtl/brs_sync.sv
module brs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= d;
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/brs_rdmux.sv
module brs_rdmux
  import brs_pkg::*;
(
  input  region_e           region,
  input  logic [IO_W-1:0]   io_off,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] rom_rdata,
  input  logic [DATA_W-1:0] sram_rdata,
  input  logic              sw_on,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    rdata = OPEN_BUS;
    if (bus_rd) begin
      case (region)
        RG_ROM:  rdata = rom_rdata;
        RG_SRAM: rdata = sram_rdata;
        RG_IO: begin
          if (io_off == OFF_SEL)
            rdata = sram_rdata;
          else if (io_off == OFF_SW)
            rdata = sw_on ? SW_ACTIVE : OPEN_BUS;
        end
        default: rdata = OPEN_BUS;
      endcase
    end
  end
endmodule

// File: rtl/banked_rom_slot.sv
module banked_rom_slot
  import brs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  localparam int ROM_AW = PAGE_W + WIN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_cs,
  input  logic [DATA_W-1:0] rom_rdata,
  output logic [WIN_W-1:0]  sram_addr,
  output logic              sram_cs,
  output logic              sram_we,
  output logic [DATA_W-1:0] sram_wdata,
  input  logic [DATA_W-1:0] sram_rdata,
  output logic              uart_cs,
  output logic              uart_reg,
  input  logic              fw_switch
);
  region_e         region;
  logic [IO_W-1:0] io_off;
  logic            sw_on;
  logic            access;

  brs_decode u_dec (.addr(bus_addr), .region(region), .io_off(io_off));

  brs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(fw_switch), .q(sw_on)
  );

  brs_rdmux u_mux (
    .region(region), .io_off(io_off), .bus_rd(bus_rd),
    .rom_rdata(rom_rdata), .sram_rdata(sram_rdata),
    .sw_on(sw_on), .rdata(bus_rdata)
  );

  assign access = bus_rd | bus_wr;

  // In the ROM window the single SRAM port is pointed at the selector
  // byte, and its low nibble becomes the page in the same cycle.
  always_comb begin
    rom_cs    = 1'b0;
    sram_cs   = 1'b0;
    sram_we   = 1'b0;
    uart_cs   = 1'b0;
    sram_addr = bus_addr[WIN_W-1:0];
    case (region)
      RG_ROM: begin
        sram_addr = SEL_LOC;
        rom_cs    = bus_rd;
        sram_cs   = bus_rd;
      end
      RG_SRAM: begin
        sram_cs = access;
        sram_we = bus_wr;
      end
      RG_IO: begin
        if (io_off == OFF_SEL) begin
          sram_cs = access;
          sram_we = bus_wr;
        end else if (io_off == OFF_UDATA || io_off == OFF_UCMD) begin
          uart_cs = access;
        end
      end
      default: ;
    endcase
  end

  assign rom_addr   = {sram_rdata[PAGE_W-1:0], bus_addr[WIN_W-1:0]};
  assign sram_wdata = bus_wdata;
  assign uart_reg   = bus_addr[0];
endmodule

// File: rtl/banked_rom_slot_chk.sv
module banked_rom_slot_chk #(
  parameter int SYNC_STAGES = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] bus_addr,
  input logic        bus_rd,
  input logic        bus_wr,
  input logic [7:0]  bus_rdata,
  input logic        fw_switch,
  input logic        rom_cs,
  input logic        sram_cs,
  input logic        sram_we,
  input logic        uart_cs
);
  localparam int CW = $clog2(SYNC_STAGES + 1) + 1;
  logic [CW-1:0] low_cnt, high_cnt;
  logic outside, sw_read;

  assign outside = (bus_addr < 16'h4000) || (bus_addr >= 16'h8000);
  assign sw_read = bus_rd && (bus_addr == 16'h7FC6);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt  <= '0;
      high_cnt <= '0;
    end else begin
      if (fw_switch) begin
        low_cnt  <= '0;
        if (high_cnt < CW'(SYNC_STAGES)) high_cnt <= high_cnt + 1'b1;
      end else begin
        high_cnt <= '0;
        if (low_cnt < CW'(SYNC_STAGES)) low_cnt <= low_cnt + 1'b1;
      end
    end
  end

  // R8
  outside_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outside |-> (!rom_cs && !sram_cs && !uart_cs && bus_rdata == 8'hFF));

  // R9
  rom_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[15:13] == 3'b010) |-> (!rom_cs && !sram_we));

  // R3
  sram_we_needs_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sram_we |-> (sram_cs && bus_wr));

  // R6
  uart_excl_sram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uart_cs |-> (!sram_cs && !rom_cs));

  // R10
  idle_open_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == 8'hFF));

  // R5
  sw_low_reads_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_read && low_cnt >= CW'(SYNC_STAGES)) |-> (bus_rdata == 8'hFF));

  // R5
  sw_high_reads_fb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_read && high_cnt >= CW'(SYNC_STAGES)) |-> (bus_rdata == 8'hFB));
endmodule

bind banked_rom_slot banked_rom_slot_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .bus_wr(bus_wr), .bus_rdata(bus_rdata), .fw_switch(fw_switch),
  .rom_cs(rom_cs), .sram_cs(sram_cs), .sram_we(sram_we), .uart_cs(uart_cs)
);

// File: tb/banked_rom_slot_test.sv
`timescale 1ns/100ps
module banked_rom_slot_test;
  localparam int STAGES = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0, bus_rdata;
  logic [16:0] rom_addr;
  logic        rom_cs;
  logic [7:0]  rom_rdata;
  logic [12:0] sram_addr;
  logic        sram_cs, sram_we;
  logic [7:0]  sram_wdata, sram_rdata;
  logic        uart_cs, uart_reg;
  logic        fw_switch = 1'b0;

  always #2.5 clk = ~clk;

  banked_rom_slot #(.SYNC_STAGES(STAGES)) uut (.*);

  function automatic logic [7:0] rom_fn(input logic [16:0] a);
    return a[7:0] ^ {a[16:13], a[12:9]} ^ 8'h5A;
  endfunction

  // SRAM model, indexed by the low address byte; test addresses differ there.
  logic [7:0] mem [256];
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
    end else if (sram_cs && sram_we) begin
      mem[sram_addr[7:0]] <= sram_wdata;
    end
  end
  assign sram_rdata = mem[sram_addr[7:0]];
  assign rom_rdata  = rom_fn(rom_addr);

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit         done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: each operation starts on a falling edge and holds one cycle.
  task automatic rd(input logic [15:0] a, input logic [7:0] e, input string req);
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(req);
    #2;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    #2;
  endtask

  task automatic idle();
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
  endtask

  // Monitor: compares read data against the scoreboard.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (bus_rd) begin
        if (exp_q.size() == 0) chk(1'b0, "scoreboard", bus_rdata, 0);
        else begin
          automatic logic [7:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          chk(bus_rdata == e, t, bus_rdata, e);
        end
      end
    end
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R10: idle bus reads open-bus; no selects after reset
    chk(bus_rdata == 8'hFF, "R10 idle", bus_rdata, 8'hFF);
    chk(!rom_cs && !sram_cs && !uart_cs, "R8 reset selects", {rom_cs, sram_cs, uart_cs}, 0);
    rd(16'h7FC6, 8'hFF, "R5 reset switch");

    // R3: selector write through I/O offset 4
    wr(16'h7FC4, 8'hA3);
    chk(sram_cs && sram_we && sram_addr == 13'h1FC4 && sram_wdata == 8'hA3, "R3 sel write",
        {sram_cs, sram_we, sram_addr, sram_wdata}, {2'b11, 13'h1FC4, 8'hA3});
    rd(16'h7FC4, 8'hA3, "R4 sel readback");
    rd(16'h4000, rom_fn({4'h3, 13'h0000}), "R1 page 3 base");
    chk(rom_cs && rom_addr == {4'h3, 13'h0000}, "R1 rom_addr", rom_addr, {4'h3, 13'h0000});
    rd(16'h5ABC, rom_fn({4'h3, 13'h1ABC}), "R1 page 3 mid");
    wr(16'h7FC4, 8'h5E);
    rd(16'h5FFF, rom_fn({4'hE, 13'h1FFF}), "R1 page E upper nibble ignored");
    rd(16'h7FC4, 8'h5E, "R4 upper nibble kept");

    // R2/R3: plain SRAM window
    wr(16'h6034, 8'h77);
    chk(sram_addr == 13'h0034 && sram_we, "R3 window write", sram_addr, 13'h0034);
    rd(16'h6034, 8'h77, "R2 window read");
    wr(16'h7E55, 8'h99);
    rd(16'h7E55, 8'h99, "R2 window read high");
    wr(16'h7FD0, 8'h3C);
    rd(16'h7FD0, 8'h3C, "R2 above io");
    wr(16'h7FBF, 8'hC3);
    rd(16'h7FBF, 8'hC3, "R2 below io");

    // R9: writes to ROM window ignored
    wr(16'h4010, 8'h12);
    chk(!rom_cs && !sram_we, "R9 rom write", {rom_cs, sram_we}, 0);
    rd(16'h6010, 8'h00, "R9 sram untouched");

    // R8: outside the decoded range
    wr(16'h8010, 8'h44);
    chk(!rom_cs && !sram_cs && !uart_cs, "R8 write high", {rom_cs, sram_cs, uart_cs}, 0);
    wr(16'h2010, 8'h45);
    chk(!sram_cs, "R8 write low", sram_cs, 0);
    rd(16'h6010, 8'h00, "R8 sram untouched");
    rd(16'h0000, 8'hFF, "R8 read 0000");
    rd(16'h3FFF, 8'hFF, "R8 read 3FFF");
    rd(16'hC000, 8'hFF, "R8 read C000");
    chk(!rom_cs && !sram_cs, "R8 read selects", {rom_cs, sram_cs}, 0);

    // R6: UART decode
    rd(16'h7FC0, 8'hFF, "R6 uart data read");
    chk(uart_cs && !uart_reg && !sram_cs, "R6 uart data", {uart_cs, uart_reg, sram_cs}, 3'b100);
    wr(16'h7FC1, 8'h01);
    chk(uart_cs && uart_reg && !sram_cs, "R6 uart cmd", {uart_cs, uart_reg, sram_cs}, 3'b110);

    // R7: remaining I/O offsets
    rd(16'h7FC2, 8'hFF, "R7 off2");
    rd(16'h7FCF, 8'hFF, "R7 off15");
    wr(16'h7FC8, 8'h55);
    chk(!sram_cs && !sram_we && !uart_cs, "R7 write ignored", {sram_cs, sram_we, uart_cs}, 0);
    rd(16'h7FC4, 8'h5E, "R7 selector intact");

    // R5: switch synchronizer latency of STAGES edges
    idle();
    fw_switch = 1'b1;
    rd(16'h7FC6, 8'hFF, "R5 rise +1");
    rd(16'h7FC6, 8'hFF, "R5 rise +2");
    rd(16'h7FC6, 8'hFB, "R5 rise +3");
    idle();
    fw_switch = 1'b0;
    rd(16'h7FC6, 8'hFB, "R5 fall +1");
    rd(16'h7FC6, 8'hFB, "R5 fall +2");
    rd(16'h7FC6, 8'hFF, "R5 fall +3");

    idle();
    #1;
    chk(bus_rdata == 8'hFF, "R10 idle end", bus_rdata, 8'hFF);
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule